// File: doc/BRIEF.md
# Over-Threshold Fault Protection Controller

This block watches a digital over-threshold flag coming from an external comparator and decides when a real fault has occurred. A fault is recognised only when the flag stays high for a programmed number of consecutive clock cycles. Shorter pulses are discarded. A recognised fault drops the soft-start enable bit, raises a sticky fault flag and latches a protection state. In that state every drive output enable is released, the phase-loop capacitor discharge is asserted and the blanking output is held on.

Recovery depends on a strap input. With the strap low, software writes the enable bit back to 1 and the block returns to operation through a timed soft-start phase. With the strap high, no register write can leave protection, and only the power-on reset brings the block back. A small write port holds the enable bit and the two programmable counts. Software can also enter protection on purpose by writing the enable bit to 0.

Top module: `fault_guard`

## Requirements
- R1: While not in protection, the state becomes protection (code 2) on the Q-th consecutive rising edge at which `overFlag` is high, where Q is the qualification count at address 1. A count of 0 acts as 1. The flag being high at fewer than Q consecutive edges never trips.
- R2: A single low sample of `overFlag` restarts the qualification count from zero.
- R3: A recognised fault clears `softEn` and sets `faultSticky`. A write of bit 0 = 0 to address 0 outside protection enters protection with `faultSticky` left at 0. A write of bit 0 = 1 outside protection has no effect. `softEn` is 0 exactly when the state is protection.
- R4: In protection, `lockOe`, `hDriveOe`, `supplyDriveOe`, `vDriveOeA` and `vDriveOeB` are all 0, and `pllDischarge` and `blankForce` are both 1.
- R5: The five drive enables are 1 only in the normal state (code 1). `pllDischarge` and `blankForce` are 0 outside protection.
- R6: After reset or re-arm the state is soft-start (code 0). It becomes normal on the S-th rising edge spent in soft-start, where S is the soft-start count at address 2. Protection is never left directly for normal.
- R7: With `hardRecover` low, a write of bit 0 = 1 to address 0 during protection moves the state to soft-start at that edge and clears `faultSticky`.
- R8: With `hardRecover` high, no write leaves protection. Only `rstN` restores operation.
- R9: While protection is latched, a still-active `overFlag` and writes to the count registers leave the state and `faultSticky` unchanged.
- R10: Under `rstN` low, the state is soft-start, `softEn` is 1, `faultSticky` is 0, the counters are cleared and both count registers take their parameter initial values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low |
| overFlag | input | 1 | Comparator over-threshold flag |
| hardRecover | input | 1 | Strap: 1 = recovery only by power-on reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Address: 0 enable bit, 1 qualification count, 2 soft-start count |
| wrData | input | DATA_W | Write data |
| state | output | 2 | 0 soft-start, 1 normal, 2 protection |
| softEn | output | 1 | Soft-start enable control bit |
| faultSticky | output | 1 | Sticky recognised-fault flag |
| lockOe | output | 1 | Lock indicator output enable |
| hDriveOe | output | 1 | Horizontal drive output enable |
| supplyDriveOe | output | 1 | Supply-control drive output enable |
| vDriveOeA | output | 1 | First vertical drive output enable |
| vDriveOeB | output | 1 | Second vertical drive output enable |
| pllDischarge | output | 1 | Phase-loop capacitor discharge control |
| blankForce | output | 1 | Continuous blanking output |

## Verification
The bench builds the block with a qualification count of 5 and a soft-start count of 6 in place of the long defaults. This brings the trip edge, the glitch restart and the soft-start expiry within a few cycles of each other. Rewriting the counts to 3, 2 and 0 at run time shows that new limits take effect, including while a soft-start count is already running and for the zero case. Toggling the strap between protection episodes, together with a power-on reset, covers both recovery policies.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [1:0] {
    ST_SOFT = 2'd0,
    ST_NORM = 2'd1,
    ST_PROT = 2'd2
  } fgState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic qualRun;
    logic ssRun;
  } fgStrobe_t;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_QUAL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_SOFT = 2'd2;
  localparam int NUM_CNT = 2;
endpackage

// File: rtl/fg_counter.sv
module fg_counter #(
  parameter int W = 16,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         limWr,
  input  logic [W-1:0] limData,
  input  logic         run,
  output logic         done
);
  localparam int EXT_W = W + 1;

  logic [W-1:0] cnt;
  logic [W-1:0] lim;
  logic [EXT_W-1:0] cntNext;

  assign cntNext = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
  // limit of zero compares below one, so it behaves as one
  assign done = run && (cntNext >= {1'b0, lim});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      lim <= INIT;
    end else begin
      if (limWr) lim <= limData;
      cnt <= run ? cntNext[W-1:0] : '0;
    end
  end
endmodule

// File: rtl/fg_datapath.sv
module fg_datapath
  import fg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] QUAL_INIT = 16'd1000,
  parameter logic [DATA_W-1:0] SS_INIT = 16'd4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              overFlag,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  fgStrobe_t         strobe,
  output logic              qualDone,
  output logic              ssDone,
  output logic              ctrlWr,
  output logic              ctrlBit
);
  logic [NUM_CNT-1:0] runVec;
  logic [NUM_CNT-1:0] limWrVec;
  logic [NUM_CNT-1:0] doneVec;

  // index 0: qualification, index 1: soft-start
  assign runVec[0]   = strobe.qualRun && overFlag;
  assign runVec[1]   = strobe.ssRun;
  assign limWrVec[0] = wrEn && (wrAddr == ADDR_QUAL);
  assign limWrVec[1] = wrEn && (wrAddr == ADDR_SOFT);

  for (genvar g = 0; g < NUM_CNT; g++) begin : gCnt
    fg_counter #(
      .W   (DATA_W),
      .INIT((g == 0) ? QUAL_INIT : SS_INIT)
    ) uCnt (
      .clk    (clk),
      .rstN   (rstN),
      .limWr  (limWrVec[g]),
      .limData(wrData),
      .run    (runVec[g]),
      .done   (doneVec[g])
    );
  end

  assign qualDone = doneVec[0];
  assign ssDone   = doneVec[1];
  assign ctrlWr   = wrEn && (wrAddr == ADDR_CTRL);
  assign ctrlBit  = wrData[0];
endmodule

// File: rtl/fg_ctrl.sv
module fg_ctrl
  import fg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hardRecover,
  input  logic      qualDone,
  input  logic      ssDone,
  input  logic      ctrlWr,
  input  logic      ctrlBit,
  output fgState_e  curState,
  output logic      softEn,
  output logic      faultSticky,
  output fgStrobe_t strobe
);
  fgState_e nxtState;
  logic nxtEn;
  logic nxtFault;

  always_comb begin
    nxtState = curState;
    nxtEn    = softEn;
    nxtFault = faultSticky;
    unique case (curState)
      ST_SOFT, ST_NORM: begin
        if (qualDone) begin
          nxtState = ST_PROT;
          nxtEn    = 1'b0;
          nxtFault = 1'b1;
        end else if (ctrlWr && !ctrlBit) begin
          nxtState = ST_PROT;
          nxtEn    = 1'b0;
        end else if (curState == ST_SOFT && ssDone) begin
          nxtState = ST_NORM;
        end
      end
      ST_PROT: begin
        if (ctrlWr && ctrlBit && !hardRecover) begin
          nxtState = ST_SOFT;
          nxtEn    = 1'b1;
          nxtFault = 1'b0;
        end
      end
      default: begin
        nxtState = ST_PROT;
        nxtEn    = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState    <= ST_SOFT;
      softEn      <= 1'b1;
      faultSticky <= 1'b0;
    end else begin
      curState    <= nxtState;
      softEn      <= nxtEn;
      faultSticky <= nxtFault;
    end
  end

  assign strobe.qualRun = (curState != ST_PROT);
  assign strobe.ssRun   = (curState == ST_SOFT);
endmodule

// File: rtl/fault_guard.sv
module fault_guard
  import fg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] QUAL_INIT = 16'd1000,
  parameter logic [DATA_W-1:0] SS_INIT = 16'd4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              overFlag,
  input  logic              hardRecover,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [1:0]        state,
  output logic              softEn,
  output logic              faultSticky,
  output logic              lockOe,
  output logic              hDriveOe,
  output logic              supplyDriveOe,
  output logic              vDriveOeA,
  output logic              vDriveOeB,
  output logic              pllDischarge,
  output logic              blankForce
);
  fgStrobe_t strobe;
  fgState_e curState;
  logic qualDone, ssDone, ctrlWr, ctrlBit;
  logic driveOn, protOn;

  fg_datapath #(
    .DATA_W   (DATA_W),
    .QUAL_INIT(QUAL_INIT),
    .SS_INIT  (SS_INIT)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .overFlag(overFlag),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .strobe  (strobe),
    .qualDone(qualDone),
    .ssDone  (ssDone),
    .ctrlWr  (ctrlWr),
    .ctrlBit (ctrlBit)
  );

  fg_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .hardRecover(hardRecover),
    .qualDone   (qualDone),
    .ssDone     (ssDone),
    .ctrlWr     (ctrlWr),
    .ctrlBit    (ctrlBit),
    .curState   (curState),
    .softEn     (softEn),
    .faultSticky(faultSticky),
    .strobe     (strobe)
  );

  assign driveOn = (curState == ST_NORM);
  assign protOn  = (curState == ST_PROT);

  assign state         = curState;
  assign lockOe        = driveOn;
  assign hDriveOe      = driveOn;
  assign supplyDriveOe = driveOn;
  assign vDriveOeA     = driveOn;
  assign vDriveOeB     = driveOn;
  assign pllDischarge  = protOn;
  assign blankForce    = protOn;
endmodule

// File: rtl/fault_guard_chk.sv
module fault_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       overFlag,
  input logic       hardRecover,
  input logic       wrEn,
  input logic [1:0] wrAddr,
  input logic       ctrlBit,
  input logic [1:0] state,
  input logic       softEn,
  input logic       faultSticky,
  input logic [4:0] driveOes,
  input logic       pllDischarge,
  input logic       blankForce
);
  localparam logic [1:0] S_SOFT = 2'd0;
  localparam logic [1:0] S_NORM = 2'd1;
  localparam logic [1:0] S_PROT = 2'd2;

  logic rearmWr;
  assign rearmWr = wrEn && (wrAddr == 2'd0) && ctrlBit;

  assert_no_single_sample_R1: assert property (@(posedge clk) disable iff (!rstN)
    !overFlag |=> !$rose(faultSticky));

  assert_enable_tracks_R3: assert property (@(posedge clk) disable iff (!rstN)
    softEn == (state != S_PROT));

  assert_safe_outputs_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PROT) |-> (driveOes == 5'd0 && pllDischarge && blankForce));

  assert_drive_normal_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    (driveOes != 5'd0) |-> (state == S_NORM && !blankForce));

  assert_via_soft_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PROT) |=> (state != S_NORM));

  assert_rearm_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PROT && !hardRecover && rearmWr) |=> (state == S_SOFT && !faultSticky));

  assert_hard_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PROT && hardRecover) |=> (state == S_PROT));

  assert_no_retrigger_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PROT && !rearmWr) |=> (state == S_PROT && $stable(faultSticky)));
endmodule

bind fault_guard fault_guard_chk uChk (
  .clk         (clk),
  .rstN        (rstN),
  .overFlag    (overFlag),
  .hardRecover (hardRecover),
  .wrEn        (wrEn),
  .wrAddr      (wrAddr),
  .ctrlBit     (wrData[0]),
  .state       (state),
  .softEn      (softEn),
  .faultSticky (faultSticky),
  .driveOes    ({lockOe, hDriveOe, supplyDriveOe, vDriveOeA, vDriveOeB}),
  .pllDischarge(pllDischarge),
  .blankForce  (blankForce)
);

// File: tb/fault_guard_test.sv
module fault_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam logic [1:0] SOFT = 2'd0, NORM = 2'd1, PROT = 2'd2;

  typedef struct packed {
    logic        over;
    logic        wr;
    logic [1:0]  addr;
    logic [15:0] data;
    logic [7:0]  cyc;
    logic [1:0]  st;
    logic        flt;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  // qualification 5, soft-start 6 at start
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 2'd0, 16'd0, 8'd5,  SOFT, 1'b0, 8'd6},  // R6 still soft
    '{1'b0, 1'b0, 2'd0, 16'd0, 8'd1,  NORM, 1'b0, 8'd6},  // R6 sixth edge
    '{1'b1, 1'b0, 2'd0, 16'd0, 8'd4,  NORM, 1'b0, 8'd1},  // R1 four highs
    '{1'b0, 1'b0, 2'd0, 16'd0, 8'd1,  NORM, 1'b0, 8'd2},  // R2 glitch
    '{1'b1, 1'b0, 2'd0, 16'd0, 8'd4,  NORM, 1'b0, 8'd2},  // R2 restarted
    '{1'b1, 1'b0, 2'd0, 16'd0, 8'd1,  PROT, 1'b1, 8'd1},  // R1 trips
    '{1'b1, 1'b0, 2'd0, 16'd0, 8'd10, PROT, 1'b1, 8'd9},  // R9 held
    '{1'b0, 1'b1, 2'd0, 16'd1, 8'd1,  SOFT, 1'b0, 8'd7},  // R7 re-arm
    '{1'b0, 1'b0, 2'd0, 16'd0, 8'd5,  SOFT, 1'b0, 8'd6},  // R6
    '{1'b0, 1'b0, 2'd0, 16'd0, 8'd1,  NORM, 1'b0, 8'd6},  // R6
    '{1'b0, 1'b1, 2'd0, 16'd1, 8'd1,  NORM, 1'b0, 8'd3},  // R3 write 1 no effect
    '{1'b0, 1'b1, 2'd0, 16'd0, 8'd1,  PROT, 1'b0, 8'd3},  // R3 software entry
    '{1'b0, 1'b1, 2'd1, 16'd3, 8'd1,  PROT, 1'b0, 8'd9},  // R9 limit write
    '{1'b0, 1'b1, 2'd0, 16'd1, 8'd1,  SOFT, 1'b0, 8'd7},  // R7
    '{1'b0, 1'b1, 2'd2, 16'd2, 8'd1,  SOFT, 1'b0, 8'd6},  // R6 new count
    '{1'b0, 1'b0, 2'd0, 16'd0, 8'd1,  NORM, 1'b0, 8'd6},  // R6
    '{1'b1, 1'b0, 2'd0, 16'd0, 8'd2,  NORM, 1'b0, 8'd1},  // R1 limit 3
    '{1'b1, 1'b0, 2'd0, 16'd0, 8'd1,  PROT, 1'b1, 8'd1}   // R1
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic overFlag = 1'b0;
  logic hardRecover = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [1:0] state;
  logic softEn, faultSticky, lockOe, hDriveOe, supplyDriveOe, vDriveOeA, vDriveOeB;
  logic pllDischarge, blankForce;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_guard #(
    .DATA_W   (DATA_W),
    .QUAL_INIT(16'd5),
    .SS_INIT  (16'd6)
  ) uut (
    .clk(clk), .rstN(rstN), .overFlag(overFlag), .hardRecover(hardRecover),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .state(state),
    .softEn(softEn), .faultSticky(faultSticky), .lockOe(lockOe),
    .hDriveOe(hDriveOe), .supplyDriveOe(supplyDriveOe), .vDriveOeA(vDriveOeA),
    .vDriveOeB(vDriveOeB), .pllDischarge(pllDischarge), .blankForce(blankForce)
  );

  task automatic check(input string what, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // full output check derived from expected state and fault flag
  task automatic checkAll(input string req, input logic [1:0] st, input logic flt);
    check("state", req, 32'(state), 32'(st));
    check("faultSticky", req, 32'(faultSticky), 32'(flt));
    check("softEn R3", req, 32'(softEn), 32'(st != PROT));
    check("drive enables R4/R5", req,
          32'({lockOe, hDriveOe, supplyDriveOe, vDriveOeA, vDriveOeB}),
          (st == NORM) ? 32'h1f : 32'h0);
    check("discharge/blank R4/R5", req, 32'({pllDischarge, blankForce}),
          (st == PROT) ? 32'h3 : 32'h0);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    cyc(1);
    wrEn = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 5000; i++) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    cyc(2);
    checkAll("R10 during reset", SOFT, 1'b0);
    rstN = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      overFlag = VECS[i].over;
      wrEn = VECS[i].wr; wrAddr = VECS[i].addr; wrData = VECS[i].data;
      cyc(int'(VECS[i].cyc));
      wrEn = 1'b0;
      checkAll($sformatf("R%0d row %0d", VECS[i].req, i), VECS[i].st, VECS[i].flt);
    end

    // R8: strap high blocks re-arm
    overFlag = 1'b0; hardRecover = 1'b1;
    writeReg(2'd0, 16'd1);
    checkAll("R8 write ignored", PROT, 1'b1);
    cyc(3);
    checkAll("R8 still held", PROT, 1'b1);

    // R10: power-on reset restores, counts back to init
    rstN = 1'b0;
    cyc(2);
    checkAll("R10 reset", SOFT, 1'b0);
    rstN = 1'b1;
    cyc(5);
    checkAll("R10 soft count reinit", SOFT, 1'b0);
    cyc(1);
    checkAll("R10 normal after 6", NORM, 1'b0);

    // R1 with strap high, qualification back at 5, trip from normal
    overFlag = 1'b1;
    cyc(4);
    checkAll("R1 reinit count", NORM, 1'b0);
    cyc(1);
    checkAll("R1 trip", PROT, 1'b1);
    overFlag = 1'b0;
    writeReg(2'd0, 16'd1);
    checkAll("R8 strap high", PROT, 1'b1);

    // R7: strap low again allows re-arm
    hardRecover = 1'b0;
    writeReg(2'd0, 16'd1);
    checkAll("R7 re-arm", SOFT, 1'b0);

    // R1: zero qualification count trips on first high edge, R3 fault in soft-start
    writeReg(2'd1, 16'd0);
    checkAll("R1 zero limit written", SOFT, 1'b0);
    overFlag = 1'b1;
    cyc(1);
    checkAll("R1 zero acts as one", PROT, 1'b1);
    overFlag = 1'b0;
    cyc(1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule